// File: doc/BRIEF.md
# Polyphase 5/2 Rational Resampler

This block is a streaming fixed-point FIR sample-rate converter. It raises the sample rate by five and lowers it by two, so every two input samples become five output samples. A 40 MHz stream, for example, becomes a 100 MHz stream on a 200 MHz system clock. Filtering uses a polyphase decomposition of a constant coefficient set. For each output the block selects one phase of the filter, forms the dot product of that phase's taps with the stored input history, then rounds and saturates the result back to the sample width.

The downstream side pulls the output stream. An output is produced only when the `request` input asks for one, so `request` can be a free-running enable or the `readyOut` of a following stage. The upstream side is throttled by `readyOut`. This output goes high for one cycle when the block lacks the sample its next output depends on. The source answers with one sample, flagged by `validIn`, on the following clock.

Top module: `poly_resampler`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the history to zero and sets the phase to 0. In the first cycle after reset is released, `readyOut` is 1, `validOut` is 0 and `dataOut` is 0.
- R2: `readyOut` is high only while the block is waiting for a new input sample, and it is never high in two consecutive cycles.
- R3: `validOut` is high only in the cycle after a clock edge at which `request` was sampled high.
- R4: A `request` sampled while the block is waiting for an input sample gives no output in the next cycle. That output is delivered on a later request, and no output is ever repeated or skipped.
- R5: Output n needs input samples up to index floor(2n/5). Once outputs stop and the source has answered every ready, the number of accepted samples equals floor(2N/5)+1, where N is the number of outputs produced.
- R6: Output n equals the sum over k of h[k]·x_up[2n−k], where x_up holds input sample i at position 5i and zeros elsewhere, and h[k] = 32·(k+1)·(40−k) for k = 0..39 in Q1.15. The sum is shifted right by 15 bits with half an LSB added first (round half up), then saturated to signed 16 bits.
- R7: A sum beyond the 16-bit range gives 32767 or −32768.
- R8: A `validIn` pulse that arrives while the block already holds the sample it needs is ignored and does not change any later output.
- R9: Successive outputs use filter phases 0, 2, 4, 1, 3 in that repeating order. A new input sample is consumed each time the phase wraps. An impulse of 32767 therefore returns h[2n] as output n.
- R10: A `request` sampled while the needed sample is present gives `validOut` high in the next cycle. In particular, the first request after a sample is accepted is always served.
- R11: While `validOut` is low, `dataOut` keeps the value of the last output (0 after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 16 | Signed input sample |
| validIn | input | 1 | Qualifies `dataIn` |
| readyOut | output | 1 | One-cycle pulse: a sample may be offered on the next clock |
| request | input | 1 | Asks for the next output sample |
| dataOut | output | 16 | Signed output sample, held between outputs |
| validOut | output | 1 | Qualifies `dataOut` for one cycle |

## Verification
The properties assume that reset is held for more than one clock edge and that `request` and `validIn` carry defined levels once reset drops. With those assumptions, `$past` and `$stable` only ever see values the reset has already set. The bench holds reset for four edges and drives every input at falling edges, always to 0 or 1. It offers a real sample only in the cycle after it saw `readyOut`. Any extra `validIn` it sends is placed in the cycle directly after a delivery, when the block is known to hold its sample, so the ignored-input case stays within what the properties expect.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;     // shift dataIn into the history
    logic compute;  // form one output with the current phase
  } rsmpStrobe_t;

  // Constant low-pass prototype: a parabolic window, exactly symmetric.
  function automatic int coefVal(input int k, input int nTaps, input int scale);
    return (k + 1) * (nTaps - k) * scale;
  endfunction

endpackage

// File: rtl/rsmp_control.sv
module rsmp_control #(
  parameter int INTERP = 5,
  parameter int DECIM  = 2,
  parameter int PH_W   = $clog2(INTERP)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   request,
  input  logic                   validIn,
  output logic                   readyOut,
  output logic                   needSample,
  output logic [PH_W-1:0]        phase,
  output rsmp_pkg::rsmpStrobe_t  strobe
);

  localparam int SUM_W = PH_W + 1;

  logic            readyQ;
  logic [SUM_W-1:0] phaseSum;
  logic            wraps;

  assign readyOut = needSample & ~readyQ;

  always_comb begin
    strobe.load    = needSample & validIn;
    strobe.compute = request & ~needSample;
    phaseSum       = {1'b0, phase} + SUM_W'(DECIM);
    wraps          = (phaseSum >= SUM_W'(INTERP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      needSample <= 1'b1;
      readyQ     <= 1'b0;
      phase      <= '0;
    end else begin
      readyQ <= readyOut;
      if (strobe.load) begin
        needSample <= 1'b0;
      end else if (strobe.compute) begin
        if (wraps) begin
          phase      <= PH_W'(phaseSum - SUM_W'(INTERP));
          needSample <= 1'b1;
        end else begin
          phase <= PH_W'(phaseSum);
        end
      end
    end
  end

endmodule

// File: rtl/rsmp_datapath.sv
module rsmp_datapath #(
  parameter int DATA_W     = 16,
  parameter int COEF_W     = 16,
  parameter int FRAC_W     = 15,
  parameter int INTERP     = 5,
  parameter int NTAPS      = 40,
  parameter int COEF_SCALE = 32,
  parameter int PH_W       = $clog2(INTERP)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  rsmp_pkg::rsmpStrobe_t        strobe,
  input  logic [PH_W-1:0]              phase,
  input  logic signed [DATA_W-1:0]     dataIn,
  output logic signed [DATA_W-1:0]     dataOut,
  output logic                         validOut
);

  localparam int TPP   = NTAPS / INTERP;
  localparam int ACC_W = DATA_W + COEF_W + $clog2(TPP) + 1;
  localparam int IDX_W = $clog2(NTAPS);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -ACC_W'(2 ** (DATA_W - 1));
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (FRAC_W - 1));

  logic signed [COEF_W-1:0] coefTab [NTAPS];
  logic signed [DATA_W-1:0] hist [TPP];
  logic signed [ACC_W-1:0]  acc, rounded, shifted;
  logic signed [DATA_W-1:0] satVal;
  logic [IDX_W-1:0]         idx;

  for (genvar k = 0; k < NTAPS; k++) begin : g_coef
    assign coefTab[k] = COEF_W'(rsmp_pkg::coefVal(k, NTAPS, COEF_SCALE));
  end

  // Newest sample sits in hist[0]; phase p pairs it with h[p].
  always_comb begin
    acc = '0;
    idx = '0;
    for (int j = 0; j < TPP; j++) begin
      idx = IDX_W'(phase) + IDX_W'(INTERP * j);
      acc = acc + ACC_W'(coefTab[idx]) * ACC_W'(hist[j]);
    end
    rounded = acc + HALF;
    shifted = rounded >>> FRAC_W;
    if (shifted > MAXV)      satVal = MAXV[DATA_W-1:0];
    else if (shifted < MINV) satVal = MINV[DATA_W-1:0];
    else                     satVal = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < TPP; j++) hist[j] <= '0;
    end else if (strobe.load) begin
      hist[0] <= dataIn;
      for (int j = 1; j < TPP; j++) hist[j] <= hist[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut  <= '0;
      validOut <= 1'b0;
    end else begin
      validOut <= strobe.compute;
      if (strobe.compute) dataOut <= satVal;
    end
  end

endmodule

// File: rtl/poly_resampler.sv
module poly_resampler #(
  parameter int DATA_W     = 16,
  parameter int COEF_W     = 16,
  parameter int FRAC_W     = 15,
  parameter int INTERP     = 5,
  parameter int DECIM      = 2,
  parameter int NTAPS      = 40,
  parameter int COEF_SCALE = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] dataIn,
  input  logic                     validIn,
  output logic                     readyOut,
  input  logic                     request,
  output logic signed [DATA_W-1:0] dataOut,
  output logic                     validOut
);

  localparam int PH_W = $clog2(INTERP);

  rsmp_pkg::rsmpStrobe_t strobe;
  logic [PH_W-1:0]       phase;
  logic                  needSample;

  rsmp_control #(
    .INTERP(INTERP), .DECIM(DECIM), .PH_W(PH_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .request(request), .validIn(validIn),
    .readyOut(readyOut), .needSample(needSample), .phase(phase), .strobe(strobe)
  );

  rsmp_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .INTERP(INTERP),
    .NTAPS(NTAPS), .COEF_SCALE(COEF_SCALE), .PH_W(PH_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .phase(phase), .dataIn(dataIn),
    .dataOut(dataOut), .validOut(validOut)
  );

endmodule

// File: rtl/rsmp_checker.sv
module rsmp_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              request,
  input logic              readyOut,
  input logic              needSample,
  input logic [DATA_W-1:0] dataOut,
  input logic              validOut
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (readyOut && !validOut));

  assert_ready_needs_R2: assert property (@(posedge clk) disable iff (rst)
    readyOut |-> needSample);

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    readyOut |=> !readyOut);

  assert_valid_after_req_R3: assert property (@(posedge clk) disable iff (rst)
    validOut |-> $past(request));

  assert_wait_no_out_R4: assert property (@(posedge clk) disable iff (rst)
    (request && needSample) |=> !validOut);

  assert_serve_next_R10: assert property (@(posedge clk) disable iff (rst)
    (request && !needSample) |=> validOut);

  assert_hold_out_R11: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> $stable(dataOut));

endmodule

bind poly_resampler rsmp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .request(request), .readyOut(readyOut),
  .needSample(needSample), .dataOut(dataOut), .validOut(validOut)
);

// File: tb/poly_resampler_tb.sv
module poly_resampler_tb;

  localparam int NT = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [15:0] dataIn = '0;
  logic validIn = 1'b0;
  logic readyOut;
  logic request = 1'b0;
  logic signed [15:0] dataOut;
  logic validOut;

  always #2.5 clk = ~clk;

  poly_resampler u_dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .validIn(validIn),
    .readyOut(readyOut), .request(request), .dataOut(dataOut), .validOut(validOut)
  );

  int checks = 0, fails = 0, cyc = 0;
  int xs [1024];
  int outs [1024];
  int nIn = 0, nOut = 0;
  int reqMode = 0;   // 0 idle, 1 alternate, 2 random
  int srcKind = 0;   // 0 random, 1 max, 2 min, 3 impulse
  bit srcOn = 0, garbageOn = 0;
  bit pend = 0, justSent = 0, realHeld = 0, delivPrev = 0, readyPrev = 0;
  int lastOut = 0;

  function automatic int coefB(int k);
    return (k + 1) * (NT - k) * 32;
  endfunction

  function automatic int refOut(int n);
    longint acc = 0;
    longint r;
    for (int k = 0; k < NT; k++) begin
      int i = 2 * n - k;
      if (i >= 0 && (i % 5) == 0) acc += longint'(coefB(k)) * longint'(xs[i / 5]);
    end
    r = (acc + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int genSample(int i);
    case (srcKind)
      1: return 32767;
      2: return -32768;
      3: return (i == 0) ? 32767 : 0;
      default: return int'($urandom_range(0, 16000)) - 8000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor, source and request driver, all away from the rising edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (validOut) begin
        check(request, "R3 valid without request", 0, 1);
        check(int'(dataOut) == refOut(nOut), "R6 output value", int'(dataOut), refOut(nOut));
        outs[nOut] = int'(dataOut);
        lastOut = int'(dataOut);
        nOut++;
      end else begin
        check(int'(dataOut) == lastOut, "R11 held output", int'(dataOut), lastOut);
      end
      if (delivPrev && request)
        check(validOut, "R10 served after sample", int'(validOut), 1);
      if (readyOut)
        check(!readyPrev, "R2 ready pulse width", 1, 0);
      delivPrev = realHeld;
      readyPrev = readyOut;
      realHeld = 0;
      if (pend) begin
        dataIn = 16'(genSample(nIn));
        xs[nIn] = int'(dataIn);
        nIn++;
        validIn = 1'b1;
        realHeld = 1;
      end else if (garbageOn && justSent) begin
        dataIn = 16'sh5a5a;
        validIn = 1'b1;
      end else begin
        validIn = 1'b0;
      end
      justSent = realHeld;
      pend = readyOut && srcOn;
      case (reqMode)
        1: request = ~request;
        2: request = 1'($urandom_range(0, 1));
        default: request = 1'b0;
      endcase
    end
  end

  task automatic doReset();
    @(posedge clk);
    reqMode = 0; srcOn = 0;
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    rst = 1'b1; validIn = 1'b0; request = 1'b0; dataIn = '0;
    nIn = 0; nOut = 0; pend = 0; justSent = 0; realHeld = 0;
    delivPrev = 0; readyPrev = 0; lastOut = 0; garbageOn = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic waitOuts(input int n);
    while (nOut < n) @(posedge clk);
  endtask

  task automatic drainCount(input string tag);
    @(posedge clk); reqMode = 0;
    repeat (12) @(posedge clk);
    check(nIn == (2 * nOut) / 5 + 1, tag, nIn, (2 * nOut) / 5 + 1);
  endtask

  task automatic test_reset();
    doReset();
    @(negedge clk);
    check(readyOut == 1'b1, "R1 ready after reset", int'(readyOut), 1);
    check(validOut == 1'b0, "R1 valid after reset", int'(validOut), 0);
    check(dataOut == 16'sd0, "R1 data after reset", int'(dataOut), 0);
  endtask

  task automatic test_alternating();
    doReset();
    @(posedge clk); srcKind = 0; srcOn = 1; reqMode = 1;
    waitOuts(60);
    drainCount("R5 input count alternating");
  endtask

  task automatic test_random_request();
    int f0;
    doReset();
    f0 = fails;
    @(posedge clk); srcKind = 0; srcOn = 1; reqMode = 2;
    waitOuts(70);
    drainCount("R5 input count random");
    check(fails == f0 && nOut >= 70, "R4 no stall loss or duplicate", fails - f0, 0);
  endtask

  task automatic test_impulse();
    doReset();
    @(posedge clk); srcKind = 3; srcOn = 1; reqMode = 1;
    waitOuts(20);
    for (int n = 0; n < 20; n++)
      check(outs[n] == coefB(2 * n), "R9 phase order impulse", outs[n], coefB(2 * n));
  endtask

  task automatic test_saturation();
    doReset();
    @(posedge clk); srcKind = 1; srcOn = 1; reqMode = 1;
    waitOuts(30);
    check(outs[29] == 32767, "R7 positive saturation", outs[29], 32767);
    doReset();
    @(posedge clk); srcKind = 2; srcOn = 1; reqMode = 2;
    waitOuts(30);
    check(outs[29] == -32768, "R7 negative saturation", outs[29], -32768);
  endtask

  task automatic test_ignored_valid();
    int f0;
    doReset();
    f0 = fails;
    @(posedge clk); srcKind = 0; srcOn = 1; garbageOn = 1; reqMode = 2;
    waitOuts(50);
    drainCount("R8 input count with extra valid");
    check(fails == f0, "R8 extra valid ignored", fails - f0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_alternating();
    test_random_request();
    test_impulse();
    test_saturation();
    test_ignored_valid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule